// File: doc/BRIEF.md
# Flash Boot and Write-Protection Clear Sequencer

This block runs once out of reset. It drives a serial-flash command engine. First it removes the flash's block write protection. Then it copies a fixed-size program image from flash into a local program memory. A host interrupt line stays high for the whole of this start-up phase. The line falls when the copy finishes, and from that point the controller takes host commands.

After start-up the block serves a host-side program/erase port. Each accepted request becomes three parts: a write-enable command, the requested program or erase command, and a status poll. The poll repeats until the flash reports it is no longer busy. The host port shows a ready flag. A request raised while the ready flag is low is held, not lost, and is taken as soon as the flag rises.

The command engine is outside this block. It has a request/grant handshake, returns bytes one per cycle with a valid strobe, and signals the end of each command with a one-cycle done pulse.

Top module: `flash_boot_seq`

## Requirements
- R1: While reset is applied, and right after it, `irq` is 1 and `cmd_ready`, `host_rdy`, `pm_we` are 0. The first command issued is write enable (opcode 0x06) on chip select 0.
- R2: Protection clear runs in this order: write enable 0x06, then status write 0x01 with data byte 0x00, then status read 0x05. The status read is reissued while bit 0 of the returned byte is 1. All other status bits are ignored.
- R3: Once the poll finds bit 0 clear, exactly one fast read (0x0B) is issued, on chip select 0, at address `IMG_BASE`, with length `IMG_LEN`.
- R4: Each byte returned during the fast read is written to program memory unchanged, at addresses 0, 1, 2, … in arrival order. Bytes returned by any other command are never written.
- R5: `irq` stays 1 until the done pulse of the fast read. It is 0 from the next cycle on and never rises again. `cmd_ready` rises in the same cycle.
- R6: `host_rdy` is 0 throughout start-up. A `host_req` held high during start-up is accepted in the first cycle `host_rdy` is 1. While `host_rdy` is 0, no host command reaches the engine.
- R7: An accepted host request issues write enable 0x06, then one command chosen by `host_kind`, then status reads 0x05 until bit 0 reads 0, all on `host_cs`. The `host_kind` encoding is 2'b00 page program 0x02 at `host_addr`, 2'b01 sector erase 0x20 at `host_addr`, and 2'b1x chip erase 0xC7. Then `host_done` pulses for exactly one cycle, and `host_rdy` is 0 until that cycle.
- R8: `eng_req` stays high, with opcode, address and chip select stable, until `eng_gnt`. No new request is raised before the `eng_done` of the previous command.
- R9: Every status write, program or erase accepted by the engine directly follows an accepted write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| eng_req | output | 1 | Command request to the engine |
| eng_op | output | 8 | Command opcode |
| eng_addr | output | 24 | Command address |
| eng_wdat | output | 8 | Data byte for the status write |
| eng_cs | output | 1 | Chip select index |
| eng_len | output | LENW | Number of bytes to read (fast read only) |
| eng_gnt | input | 1 | Engine accepts the request this cycle |
| eng_rvalid | input | 1 | Returned byte valid |
| eng_rdata | input | 8 | Returned byte |
| eng_done | input | 1 | Command finished (one-cycle pulse) |
| pm_we | output | 1 | Program memory write strobe |
| pm_addr | output | PMW | Program memory byte address |
| pm_wdata | output | 8 | Program memory write data |
| host_req | input | 1 | Host program/erase request, held until accepted |
| host_kind | input | 2 | Request kind: 00 page program, 01 sector erase, 1x chip erase |
| host_cs | input | 1 | Chip select for the request |
| host_addr | input | 24 | Flash address for the request |
| host_rdy | output | 1 | A request is accepted in a cycle where this and host_req are high |
| host_done | output | 1 | One-cycle pulse when a request has fully finished |
| cmd_ready | output | 1 | Start-up complete; host commands allowed |
| irq | output | 1 | High while start-up is in progress |

## Verification
The bench returns status bytes with bit 0 set, and also with every bit except bit 0 set. A design that tests the wrong bit, or the whole byte, would either stop polling early or poll forever. A host request is raised before reset is released and kept high through start-up. A design that let it in early would put a program command ahead of the fast read, and one that dropped it would never produce `host_done`. The bench measures the exact cycle `irq` falls against the fast read's done pulse, and counts program-memory writes, so a status byte written into memory or a shifted address is caught. Grant delays vary between commands, so a request that drops or changes before its grant is flagged by the engine model.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  localparam int FL_AW = 24;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_PP    = 8'h02;
  localparam logic [7:0] OP_SE    = 8'h20;
  localparam logic [7:0] OP_CE    = 8'hC7;

  typedef enum logic [2:0] {
    SQ_PWREN, SQ_PWRSR, SQ_PPOLL, SQ_LOAD,
    SQ_IDLE,  SQ_HWREN, SQ_HOP,   SQ_HPOLL
  } seq_st_e;

  typedef enum logic [1:0] {PT_IDLE, PT_REQ, PT_WAIT} port_st_e;

  typedef struct packed {
    logic [7:0]       op;
    logic [FL_AW-1:0] addr;
    logic [7:0]       wdat;
    logic             cs;
  } fcmd_t;

endpackage

// File: rtl/fbs_rst_sync.sv
module fbs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/fbs_cmd_port.sv
module fbs_cmd_port
  import fbs_pkg::*;
#(
  parameter int LENW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  fcmd_t            cmd_in,
  input  logic [LENW-1:0]  len_in,
  output logic             eng_req,
  output logic [7:0]       eng_op,
  output logic [FL_AW-1:0] eng_addr,
  output logic [7:0]       eng_wdat,
  output logic             eng_cs,
  output logic [LENW-1:0]  eng_len,
  input  logic             eng_gnt,
  input  logic             eng_rvalid,
  input  logic             rd_bit0,
  input  logic             eng_done,
  output logic             fin,
  output logic             busy
);
  port_st_e        pst_q, pst_d;
  fcmd_t           cmd_q;
  logic [LENW-1:0] len_q;
  logic            busy_q;
  logic [7:0]      prev_op_q;
  logic            load, accept, stat_en;

  assign load    = go && (pst_q == PT_IDLE);
  assign accept  = (pst_q == PT_REQ) && eng_gnt;
  assign stat_en = (pst_q == PT_WAIT) && eng_rvalid;

  always_comb begin
    pst_d = pst_q;
    case (pst_q)
      PT_IDLE: if (go)       pst_d = PT_REQ;
      PT_REQ:  if (eng_gnt)  pst_d = PT_WAIT;
      PT_WAIT: if (eng_done) pst_d = PT_IDLE;
      default:               pst_d = PT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst_q     <= PT_IDLE;
      cmd_q     <= '0;
      len_q     <= '0;
      busy_q    <= 1'b0;
      prev_op_q <= 8'h00;
    end else begin
      pst_q <= pst_d;
      if (load) begin
        cmd_q <= cmd_in;
        len_q <= len_in;
      end
      if (stat_en) busy_q    <= rd_bit0;
      if (accept)  prev_op_q <= cmd_q.op;
    end
  end

  assign eng_req  = (pst_q == PT_REQ);
  assign eng_op   = cmd_q.op;
  assign eng_addr = cmd_q.addr;
  assign eng_wdat = cmd_q.wdat;
  assign eng_cs   = cmd_q.cs;
  assign eng_len  = len_q;
  assign fin      = (pst_q == PT_WAIT) && eng_done;
  assign busy     = busy_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_gnt) |=> (eng_req && $stable(eng_op) && $stable(eng_addr) && $stable(eng_cs))); // R8
  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (pst_q == PT_IDLE)); // R8
  AST_WREN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (eng_op == OP_PP || eng_op == OP_SE || eng_op == OP_CE || eng_op == OP_WRSR))
      |-> (prev_op_q == OP_WREN)); // R9
endmodule

// File: rtl/fbs_img_copy.sv
module fbs_img_copy #(
  parameter int IMG_LEN = 64,
  parameter int PMW     = 6,
  parameter int CW      = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           rvalid,
  input  logic [7:0]     rdata,
  output logic           pm_we,
  output logic [PMW-1:0] pm_addr,
  output logic [7:0]     pm_wdata
);
  logic [CW-1:0]  cnt_q;
  logic           we_q;
  logic [PMW-1:0] addr_q;
  logic [7:0]     data_q;
  logic           take;

  assign take = active && rvalid && (cnt_q < CW'(IMG_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= 8'h00;
    end else begin
      we_q <= take;
      if (take) begin
        cnt_q  <= cnt_q + 1'b1;
        addr_q <= cnt_q[PMW-1:0];
        data_q <= rdata;
      end
    end
  end

  assign pm_we    = we_q;
  assign pm_addr  = addr_q;
  assign pm_wdata = data_q;

  AST_PM_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> $past(active && rvalid)); // R4
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(IMG_LEN)); // R4
endmodule

// File: rtl/flash_boot_seq.sv
module flash_boot_seq
  import fbs_pkg::*;
#(
  parameter int          IMG_LEN  = 64,
  parameter logic [23:0] IMG_BASE = 24'h010000,
  localparam int         LENW     = $clog2(IMG_LEN + 1),
  localparam int         PMW      = (IMG_LEN > 1) ? $clog2(IMG_LEN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            eng_req,
  output logic [7:0]      eng_op,
  output logic [23:0]     eng_addr,
  output logic [7:0]      eng_wdat,
  output logic            eng_cs,
  output logic [LENW-1:0] eng_len,
  input  logic            eng_gnt,
  input  logic            eng_rvalid,
  input  logic [7:0]      eng_rdata,
  input  logic            eng_done,
  output logic            pm_we,
  output logic [PMW-1:0]  pm_addr,
  output logic [7:0]      pm_wdata,
  input  logic            host_req,
  input  logic [1:0]      host_kind,
  input  logic            host_cs,
  input  logic [23:0]     host_addr,
  output logic            host_rdy,
  output logic            host_done,
  output logic            cmd_ready,
  output logic            irq
);
  logic            srst_n;
  seq_st_e         st_q, st_d;
  logic            launch_q, launch_d;
  logic            init_q, init_d;
  logic            hdone_q, hdone_d;
  logic [1:0]      hk_q;
  logic            hc_q;
  logic [23:0]     ha_q;
  logic            take_host;
  logic            fin, busy;
  fcmd_t           cmd;
  logic [LENW-1:0] len;

  fbs_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign take_host = (st_q == SQ_IDLE) && host_req;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_PWREN: if (fin)          st_d = SQ_PWRSR;
      SQ_PWRSR: if (fin)          st_d = SQ_PPOLL;
      SQ_PPOLL: if (fin && !busy) st_d = SQ_LOAD;
      SQ_LOAD:  if (fin)          st_d = SQ_IDLE;
      SQ_IDLE:  if (host_req)     st_d = SQ_HWREN;
      SQ_HWREN: if (fin)          st_d = SQ_HOP;
      SQ_HOP:   if (fin)          st_d = SQ_HPOLL;
      SQ_HPOLL: if (fin && !busy) st_d = SQ_IDLE;
      default:                    st_d = SQ_IDLE;
    endcase
    launch_d = (st_d != SQ_IDLE) && (fin || take_host);
    init_d   = init_q || ((st_q == SQ_LOAD) && fin);
    hdone_d  = (st_q == SQ_HPOLL) && fin && !busy;
  end

  always_comb begin
    cmd = '0;
    len = '0;
    case (st_q)
      SQ_PWREN: cmd.op = OP_WREN;
      SQ_PWRSR: begin cmd.op = OP_WRSR; cmd.wdat = 8'h00; end
      SQ_PPOLL: cmd.op = OP_RDSR;
      SQ_LOAD: begin
        cmd.op   = OP_FREAD;
        cmd.addr = IMG_BASE;
        len      = LENW'(IMG_LEN);
      end
      SQ_HWREN: begin cmd.op = OP_WREN; cmd.cs = hc_q; end
      SQ_HOP: begin
        cmd.cs = hc_q;
        if (hk_q[1])      cmd.op = OP_CE;
        else begin
          cmd.op   = hk_q[0] ? OP_SE : OP_PP;
          cmd.addr = ha_q;
        end
      end
      SQ_HPOLL: begin cmd.op = OP_RDSR; cmd.cs = hc_q; end
      default: cmd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q     <= SQ_PWREN;
      launch_q <= 1'b1;
      init_q   <= 1'b0;
      hdone_q  <= 1'b0;
      hk_q     <= 2'b00;
      hc_q     <= 1'b0;
      ha_q     <= '0;
    end else begin
      st_q     <= st_d;
      launch_q <= launch_d;
      init_q   <= init_d;
      hdone_q  <= hdone_d;
      if (take_host) begin
        hk_q <= host_kind;
        hc_q <= host_cs;
        ha_q <= host_addr;
      end
    end
  end

  fbs_cmd_port #(.LENW(LENW)) u_port (
    .clk(clk), .rst_n(srst_n), .go(launch_q), .cmd_in(cmd), .len_in(len),
    .eng_req(eng_req), .eng_op(eng_op), .eng_addr(eng_addr), .eng_wdat(eng_wdat),
    .eng_cs(eng_cs), .eng_len(eng_len), .eng_gnt(eng_gnt), .eng_rvalid(eng_rvalid),
    .rd_bit0(eng_rdata[0]), .eng_done(eng_done), .fin(fin), .busy(busy)
  );

  fbs_img_copy #(.IMG_LEN(IMG_LEN), .PMW(PMW), .CW(LENW)) u_copy (
    .clk(clk), .rst_n(srst_n), .active(st_q == SQ_LOAD), .rvalid(eng_rvalid),
    .rdata(eng_rdata), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata)
  );

  assign host_rdy  = (st_q == SQ_IDLE);
  assign host_done = hdone_q;
  assign cmd_ready = init_q;
  assign irq       = ~init_q;

  AST_IRQ_STAYS_LOW: assert property (@(posedge clk) disable iff (!srst_n)
    !irq |=> !irq); // R5
  AST_RDY_AFTER_INIT: assert property (@(posedge clk) disable iff (!srst_n)
    host_rdy |-> (cmd_ready && !irq)); // R6
  AST_BOOT_CS0: assert property (@(posedge clk) disable iff (!srst_n)
    (eng_req && eng_op == OP_FREAD) |-> !eng_cs); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!srst_n)
    host_done |=> !host_done); // R7
endmodule

// File: tb/test_flash_boot_seq.sv
module test_flash_boot_seq;
  localparam int CLK_P    = 10;
  localparam int IMG_LEN  = 64;
  localparam logic [23:0] IMG_BASE = 24'h010000;
  localparam int LENW     = $clog2(IMG_LEN + 1);
  localparam int PMW      = $clog2(IMG_LEN);

  logic clk = 1'b0, rst_n = 1'b0;
  logic eng_req, eng_cs, pm_we, host_rdy, host_done, cmd_ready, irq;
  logic [7:0] eng_op, eng_wdat, pm_wdata;
  logic [23:0] eng_addr;
  logic [LENW-1:0] eng_len;
  logic [PMW-1:0] pm_addr;
  logic eng_gnt = 0, eng_rvalid = 0, eng_done = 0;
  logic [7:0] eng_rdata = 0;
  logic host_req = 0, host_cs = 0;
  logic [1:0] host_kind = 0;
  logic [23:0] host_addr = 0;

  int total = 0, fails = 0, cyc = 0;
  int cmd_n = 0, proto_err = 0, polls_left = 0, rd_done_cyc = -1;
  int irq_low_cyc = -1, rdy_rise_cyc = -1, pm_n = 0, pm_bad = 0;
  logic [7:0]  log_op[0:63];
  logic [23:0] log_addr[0:63];
  logic [7:0]  log_wdat[0:63];
  logic        log_cs[0:63];
  int          log_len[0:63];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_boot_seq #(.IMG_LEN(IMG_LEN), .IMG_BASE(IMG_BASE)) i_flash_boot_seq (
    .clk, .rst_n, .eng_req, .eng_op, .eng_addr, .eng_wdat, .eng_cs, .eng_len,
    .eng_gnt, .eng_rvalid, .eng_rdata, .eng_done, .pm_we, .pm_addr, .pm_wdata,
    .host_req, .host_kind, .host_cs, .host_addr, .host_rdy, .host_done,
    .cmd_ready, .irq);

  function automatic logic [7:0] img(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // engine model
  initial forever begin
    @(negedge clk);
    if (eng_req) begin
      logic [7:0] op0;
      op0 = eng_op;
      repeat (cmd_n % 3) begin
        @(negedge clk);
        if (!eng_req || eng_op !== op0) proto_err++;
      end
      log_op[cmd_n] = eng_op; log_addr[cmd_n] = eng_addr; log_wdat[cmd_n] = eng_wdat;
      log_cs[cmd_n] = eng_cs; log_len[cmd_n] = int'(eng_len);
      eng_gnt = 1;
      @(negedge clk); eng_gnt = 0;
      repeat (2) begin if (eng_req) proto_err++; @(negedge clk); end
      if (op0 == 8'h05) begin
        eng_rvalid = 1;
        eng_rdata = (polls_left > 0) ? 8'h03 : 8'hFC;
        if (polls_left > 0) polls_left--;
        @(negedge clk); eng_rvalid = 0;
      end else if (op0 == 8'h0B) begin
        for (int i = 0; i < int'(eng_len); i++) begin
          eng_rvalid = 1; eng_rdata = img(i);
          @(negedge clk);
        end
        eng_rvalid = 0;
      end
      if (eng_req) proto_err++;
      eng_done = 1;
      if (op0 == 8'h0B) rd_done_cyc = cyc;
      cmd_n++;
      @(negedge clk); eng_done = 0;
    end
  end

  // observation monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && !irq && irq_low_cyc < 0) irq_low_cyc = cyc;
    if (rst_n && cmd_ready && rdy_rise_cyc < 0) rdy_rise_cyc = cyc;
    if (pm_we) begin
      if (pm_addr !== PMW'(pm_n) || pm_wdata !== img(pm_n)) pm_bad++;
      pm_n++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic t_reset();
    rst_n = 0;
    polls_left = 2;
    host_req = 1; host_kind = 2'b00; host_cs = 1; host_addr = 24'h000300;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", irq, 1);
    chk("R1 cmd_ready in reset", cmd_ready, 0);
    chk("R1 host_rdy in reset", host_rdy, 0);
    chk("R1 pm_we in reset", pm_we, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq after reset", irq, 1);
    chk("R6 host_rdy low after reset", host_rdy, 0);
  endtask

  task automatic t_boot_and_held_host();
    int rdy_early = 0, seen_done = 0;
    while (!host_rdy) begin
      @(negedge clk);
      if (!cmd_ready && host_rdy) rdy_early++;
    end
    chk("R6 host_rdy during init", rdy_early, 0);
    chk("R6 cmd_ready with host_rdy", cmd_ready, 1);
    @(negedge clk); host_req = 0;
    chk("R1 first op wren", log_op[0], 8'h06);
    chk("R1 first cs0", log_cs[0], 0);
    chk("R2 second op wrsr", log_op[1], 8'h01);
    chk("R2 wrsr data zero", log_wdat[1], 8'h00);
    for (int k = 2; k < 5; k++) chk("R2 status poll", log_op[k], 8'h05);
    chk("R3 fast read op", log_op[5], 8'h0B);
    chk("R3 fast read addr", log_addr[5], IMG_BASE);
    chk("R3 fast read len", log_len[5], IMG_LEN);
    chk("R3 fast read cs0", log_cs[5], 0);
    chk("R4 pm write count", pm_n, IMG_LEN);
    chk("R4 pm addr/data", pm_bad, 0);
    chk("R5 irq fall cycle", irq_low_cyc, rd_done_cyc + 1);
    chk("R5 cmd_ready rise cycle", rdy_rise_cyc, rd_done_cyc + 1);
    while (!seen_done) begin @(negedge clk); if (host_done) seen_done = 1; end
    chk("R6 held req wren", log_op[6], 8'h06);
    chk("R6 held req wren cs", log_cs[6], 1);
    chk("R7 page program op", log_op[7], 8'h02);
    chk("R7 page program addr", log_addr[7], 24'h000300);
    chk("R7 poll after program", log_op[8], 8'h05);
    chk("R7 cmd count", cmd_n, 9);
    chk("R5 irq stays low", irq, 0);
  endtask

  task automatic t_host(logic [1:0] kind, logic cs, logic [23:0] addr, int polls,
                        logic [7:0] exp_op);
    int n0, rdy_bad = 0, got = 0;
    n0 = cmd_n;
    polls_left = polls;
    @(negedge clk);
    host_req = 1; host_kind = kind; host_cs = cs; host_addr = addr;
    while (!host_rdy) @(negedge clk);
    @(negedge clk); host_req = 0;
    while (!got) begin
      if (host_done) got = 1;
      else if (host_rdy) rdy_bad++;
      if (!got) @(negedge clk);
    end
    chk("R7 host_rdy low while busy", rdy_bad, 0);
    @(negedge clk);
    chk("R7 host_done single pulse", host_done, 0);
    chk("R7 wren first", log_op[n0], 8'h06);
    chk("R7 wren cs", log_cs[n0], cs);
    chk("R7 op by kind", log_op[n0+1], exp_op);
    chk("R7 op cs", log_cs[n0+1], cs);
    if (exp_op != 8'hC7) chk("R7 op addr", log_addr[n0+1], addr);
    for (int k = 0; k <= polls; k++) chk("R7 busy poll", log_op[n0+2+k], 8'h05);
    chk("R7 command count", cmd_n, n0 + 3 + polls);
    chk("R4 no pm writes from host ops", pm_n, IMG_LEN);
    chk("R8 engine protocol", proto_err, 0);
  endtask

  initial begin
    t_reset();
    t_boot_and_held_host();
    t_host(2'b01, 1'b0, 24'h004000, 3, 8'h20);
    t_host(2'b10, 1'b1, 24'h123456, 0, 8'hC7);
    t_host(2'b11, 1'b0, 24'h000000, 1, 8'hC7);
    t_host(2'b00, 1'b0, 24'h0FFF00, 2, 8'h02);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule